// File: doc/BRIEF.md
# Address Watchpoint Unit

The block watches the memory and instruction-fetch traffic of a processor core against up to four programmable address slots. Each slot carries a watched address, a 4-bit field that picks the access type and the length of the watched window, and a pair of enable bits. One is local and is cleared by hardware on a task switch. The other is global and stays set until software clears it. On every observed access, each enabled slot compares the access against its window. Any hit, or an incoming single-step or task-switch event, sets sticky cause bits in a status register and produces a one-cycle trap pulse.

Software reaches the slots, the control register and the status register through a simple register port with a combinational read path. The access port carries an address, a size given as the log2 of the byte count, and a kind (fetch, read or write). Delivering the exception, watching I/O ports and the pipeline slowdown effect are left to the surrounding core. The slowdown flags are only stored.

Top module: `wp_watch`

## Requirements
- R1: After reset the four address slots, the control register and the status register read zero, and the trap output is low.
- R2: Register select 0 to 3 addresses the slots, 4 the control register and 5 the status register. Control bits 10 to 15 always read zero. Enable bits 0 to 7, slowdown bits 8 and 9 and the slot fields in bits 16 to 31 read back as written.
- R3: Slot n takes part in matching when control bit 2n (local) or bit 2n+1 (global) is set. Either bit alone is enough.
- R4: A task-switch event clears every local enable bit (the even bits 0 to 6), keeps the global enable bits and sets status bit 15. It takes precedence over a control write in the same cycle.
- R5: Slot n's type code sits in control bits 16+4n and 17+4n. Code 00 matches only a fetch (kind 00) whose address equals the slot address exactly, and it ignores the access size.
- R6: Type code 01 matches only data writes (kind 10). Code 11 matches data reads (kind 01) and writes. Code 10 never matches.
- R7: The length code in control bits 18+4n and 19+4n selects 1 (00), 2 (01), 4 (11) or 8 (10) bytes. A data access hits when its byte range overlaps the slot address aligned down to that length and extended over that length.
- R8: Status bits 0 to 3 are set for each slot that hits, several in one cycle if several hit. Hardware never clears them, so later hits accumulate.
- R9: A single-step event sets status bit 14 and causes a trap.
- R10: The trap output is high for exactly the one cycle after a cycle with a slot hit, a step event or a task-switch event.
- R11: A write to the status register replaces it with the written value limited to bits 0 to 3, 14 and 15. Causes arriving in the same cycle are ORed on top of the written value.
- R12: With zero written to the control register and to all address slots, no access causes a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0-3 slots, 4 control, 5 status |
| cfg_wdata | input | REG_W | Register write data |
| cfg_rdata | output | REG_W | Combinational read data for cfg_sel |
| acc_valid | input | 1 | An access is observed this cycle |
| acc_addr | input | ADDR_W | Access byte address |
| acc_size | input | 2 | log2 of the access byte count |
| acc_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 none |
| step_evt | input | 1 | Single-step event |
| tswitch_evt | input | 1 | Task-switch event |
| trap_o | output | 1 | One-cycle trap pulse |

## Verification
The assertions take for granted that the events and the access strobe are clean single-cycle levels. They also assume no reset is released in the middle of an access, because the trap property looks back one cycle to the cause inputs. The stimulus raises each cause for exactly one cycle, leaves an idle cycle after it so that the end of each pulse can be seen, and uses register writes to the status register to clear causes. The one intentional overlap of a status write with a hit is driven separately, so that the precedence rule is checked on purpose.

// File: rtl/wp_pkg.sv
package wp_pkg;
   localparam int CTRL_W      = 32;
   localparam int STS_W       = 16;
   localparam int STS_STEP    = 14;
   localparam int STS_SWITCH  = 15;
   localparam int FIELD_BASE  = 16;
   localparam int FIELD_W     = 4;

   typedef enum logic [2:0] {
      SEL_SLOT0  = 3'd0,
      SEL_SLOT1  = 3'd1,
      SEL_SLOT2  = 3'd2,
      SEL_SLOT3  = 3'd3,
      SEL_CTRL   = 3'd4,
      SEL_STATUS = 3'd5
   } reg_sel_e;

   typedef enum logic [1:0] {
      K_FETCH = 2'b00,
      K_READ  = 2'b01,
      K_WRITE = 2'b10,
      K_NONE  = 2'b11
   } acc_kind_e;

   typedef enum logic [1:0] {
      T_EXEC  = 2'b00,
      T_WRITE = 2'b01,
      T_NEVER = 2'b10,
      T_RDWR  = 2'b11
   } wp_type_e;

   function automatic logic [1:0] len_log2(input logic [1:0] code);
      case (code)
         2'b00:   len_log2 = 2'd0;
         2'b01:   len_log2 = 2'd1;
         2'b11:   len_log2 = 2'd2;
         default: len_log2 = 2'd3;
      endcase
   endfunction

   function automatic logic [CTRL_W-1:0] ctrl_keep_mask(input int n);
      logic [CTRL_W-1:0] m;
      m = '0;
      m[9:8] = 2'b11;
      for (int i = 0; i < n; i++) begin
         m[2*i]   = 1'b1;
         m[2*i+1] = 1'b1;
         m[FIELD_BASE + FIELD_W*i +: FIELD_W] = '1;
      end
      return m;
   endfunction

   function automatic logic [CTRL_W-1:0] local_en_mask(input int n);
      logic [CTRL_W-1:0] m;
      m = '0;
      for (int i = 0; i < n; i++) m[2*i] = 1'b1;
      return m;
   endfunction

   function automatic logic [STS_W-1:0] sts_keep_mask(input int n);
      logic [STS_W-1:0] m;
      m = '0;
      m[STS_STEP]   = 1'b1;
      m[STS_SWITCH] = 1'b1;
      for (int i = 0; i < n; i++) m[i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/wp_addr_bank.sv
module wp_addr_bank #(
   parameter int ADDR_W    = 32,
   parameter int NUM_SLOTS = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [2:0]                         wr_sel,
   input  logic [ADDR_W-1:0]                  wr_data,
   output logic [NUM_SLOTS-1:0][ADDR_W-1:0]   slot_addr
);
   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_addr[g] <= '0;
         else if (wr_en && (wr_sel == 3'(g)))
            slot_addr[g] <= wr_data;
      end
   end
endmodule

// File: rtl/wp_ctrl_reg.sv
module wp_ctrl_reg
   import wp_pkg::*;
#(
   parameter int NUM_SLOTS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              tswitch,
   output logic [CTRL_W-1:0] ctrl_q
);
   localparam logic [CTRL_W-1:0] KEEP  = ctrl_keep_mask(NUM_SLOTS);
   localparam logic [CTRL_W-1:0] LOCAL = local_en_mask(NUM_SLOTS);

   logic [CTRL_W-1:0] base_d;
   logic [CTRL_W-1:0] ctrl_d;

   always_comb begin
      base_d = wr_en ? (wr_data & KEEP) : ctrl_q;
      ctrl_d = tswitch ? (base_d & ~LOCAL) : base_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= ctrl_d;
   end
endmodule

// File: rtl/wp_slot_cmp.sv
module wp_slot_cmp
   import wp_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] slot_addr,
   input  logic [1:0]        enables,
   input  logic [3:0]        field,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        acc_size,
   input  logic [1:0]        acc_kind,
   output logic              hit
);
   localparam int XW = ADDR_W + 1;

   logic [1:0]    type_code;
   logic [1:0]    lg;
   logic [XW-1:0] wmask, wbase, wend, abeg, aend;
   logic          is_data, overlap, type_ok;

   always_comb begin
      type_code = field[1:0];
      lg        = len_log2(field[3:2]);
      wmask     = (XW'(1) << lg) - XW'(1);
      wbase     = {1'b0, slot_addr} & ~wmask;
      wend      = wbase | wmask;
      abeg      = {1'b0, acc_addr};
      aend      = abeg + ((XW'(1) << acc_size) - XW'(1));
      overlap   = (abeg <= wend) && (aend >= wbase);
      is_data   = (acc_kind == K_READ) || (acc_kind == K_WRITE);
      case (type_code)
         T_EXEC:  type_ok = (acc_kind == K_FETCH) && (acc_addr == slot_addr);
         T_WRITE: type_ok = (acc_kind == K_WRITE) && overlap;
         T_RDWR:  type_ok = is_data && overlap;
         default: type_ok = 1'b0;
      endcase
      hit = acc_valid && (|enables) && type_ok;
   end
endmodule

// File: rtl/wp_status_reg.sv
module wp_status_reg
   import wp_pkg::*;
#(
   parameter int NUM_SLOTS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [STS_W-1:0]     wr_data,
   input  logic [NUM_SLOTS-1:0] hits,
   input  logic                 step,
   input  logic                 tswitch,
   output logic [STS_W-1:0]     status_q,
   output logic                 trap_q
);
   localparam logic [STS_W-1:0] KEEP = sts_keep_mask(NUM_SLOTS);

   logic [STS_W-1:0] set_v;
   logic [STS_W-1:0] status_d;
   logic             cause;

   always_comb begin
      set_v               = '0;
      set_v[NUM_SLOTS-1:0] = hits;
      set_v[STS_STEP]     = step;
      set_v[STS_SWITCH]   = tswitch;
      cause               = |set_v;
      status_d            = (wr_en ? (wr_data & KEEP) : status_q) | set_v;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         trap_q   <= 1'b0;
      end else begin
         status_q <= status_d;
         trap_q   <= cause;
      end
   end
endmodule

// File: rtl/wp_watch.sv
module wp_watch
   import wp_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int REG_W     = 32,
   parameter int NUM_SLOTS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        acc_size,
   input  logic [1:0]        acc_kind,
   input  logic              step_evt,
   input  logic              tswitch_evt,
   output logic              trap_o
);
   initial begin
      assert (NUM_SLOTS >= 1 && NUM_SLOTS <= 4)
         else $error("NUM_SLOTS must be 1 to 4");
      assert (REG_W >= CTRL_W)
         else $error("REG_W must hold the control register");
      assert (ADDR_W >= 4 && ADDR_W <= REG_W)
         else $error("ADDR_W out of range");
   end

   logic                             we_addr, we_ctrl, we_sts;
   logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr;
   logic [CTRL_W-1:0]                ctrl_q;
   logic [STS_W-1:0]                 status_q;
   logic [NUM_SLOTS-1:0]             hits;

   always_comb begin
      we_addr = cfg_we && (cfg_sel < 3'(NUM_SLOTS));
      we_ctrl = cfg_we && (cfg_sel == SEL_CTRL);
      we_sts  = cfg_we && (cfg_sel == SEL_STATUS);
   end

   wp_addr_bank #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (we_addr),
      .wr_sel    (cfg_sel),
      .wr_data   (cfg_wdata[ADDR_W-1:0]),
      .slot_addr (slot_addr)
   );

   wp_ctrl_reg #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (we_ctrl),
      .wr_data (cfg_wdata[CTRL_W-1:0]),
      .tswitch (tswitch_evt),
      .ctrl_q  (ctrl_q)
   );

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
      wp_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
         .slot_addr (slot_addr[g]),
         .enables   (ctrl_q[2*g +: 2]),
         .field     (ctrl_q[FIELD_BASE + FIELD_W*g +: FIELD_W]),
         .acc_valid (acc_valid),
         .acc_addr  (acc_addr),
         .acc_size  (acc_size),
         .acc_kind  (acc_kind),
         .hit       (hits[g])
      );
   end

   wp_status_reg #(.NUM_SLOTS(NUM_SLOTS)) u_sts (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (we_sts),
      .wr_data  (cfg_wdata[STS_W-1:0]),
      .hits     (hits),
      .step     (step_evt),
      .tswitch  (tswitch_evt),
      .status_q (status_q),
      .trap_q   (trap_o)
   );

   always_comb begin
      cfg_rdata = '0;
      if (cfg_sel < 3'(NUM_SLOTS)) begin
         for (int i = 0; i < NUM_SLOTS; i++)
            if (cfg_sel == 3'(i)) cfg_rdata = REG_W'(slot_addr[i]);
      end else if (cfg_sel == SEL_CTRL) begin
         cfg_rdata = REG_W'(ctrl_q);
      end else if (cfg_sel == SEL_STATUS) begin
         cfg_rdata = REG_W'(status_q);
      end
   end
endmodule

// File: rtl/wp_watch_chk.sv
module wp_watch_chk
   import wp_pkg::*;
#(
   parameter int NUM_SLOTS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [2:0]        cfg_sel,
   input logic              acc_valid,
   input logic              step_evt,
   input logic              tswitch_evt,
   input logic              trap_o,
   input logic [CTRL_W-1:0] ctrl_q,
   input logic [STS_W-1:0]  status_q
);
   localparam logic [CTRL_W-1:0] LOCAL = local_en_mask(NUM_SLOTS);

   // R2: reserved control bits never hold a one
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[15:10] == 6'b0);

   // R4: local enables gone after a task switch
   a_r4_local_clear: assert property (@(posedge clk) disable iff (!rst_n)
      tswitch_evt |=> ((ctrl_q & LOCAL) == '0));

   // R4: task switch recorded in status
   a_r4_switch_status: assert property (@(posedge clk) disable iff (!rst_n)
      tswitch_evt |=> status_q[STS_SWITCH]);

   // R9: single step recorded in status
   a_r9_step_status: assert property (@(posedge clk) disable iff (!rst_n)
      step_evt |=> status_q[STS_STEP]);

   // R8: without a status write no status bit falls
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_sel == SEL_STATUS) |=> (($past(status_q) & ~status_q) == '0));

   // R10: a trap needs a cause in the previous cycle
   a_r10_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> $past(step_evt || tswitch_evt || acc_valid));

   // R12: nothing enabled and no events means no trap
   a_r12_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[7:0] == 8'h00 && !step_evt && !tswitch_evt) |=> !trap_o);
endmodule

bind wp_watch wp_watch_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_we      (cfg_we),
   .cfg_sel     (cfg_sel),
   .acc_valid   (acc_valid),
   .step_evt    (step_evt),
   .tswitch_evt (tswitch_evt),
   .trap_o      (trap_o),
   .ctrl_q      (ctrl_q),
   .status_q    (status_q)
);

// File: tb/wp_watch_test.sv
module wp_watch_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = 3'd5;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_size = '0;
   logic [1:0]  acc_kind = 2'b11;
   logic        step_evt = 1'b0;
   logic        tswitch_evt = 1'b0;
   logic        trap_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic        trap;
      logic [31:0] sts;
      string       tag;
   } item_t;
   item_t sb[$];
   item_t it;

   always #4 clk = ~clk;

   wp_watch uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
      .acc_addr(acc_addr), .acc_size(acc_size), .acc_kind(acc_kind),
      .step_evt(step_evt), .tswitch_evt(tswitch_evt), .trap_o(trap_o)
   );

   // monitor: pops expectations after each edge
   always @(posedge clk) begin
      #2;
      if (sb.size() != 0) begin
         it = sb.pop_front();
         checks++;
         if (trap_o !== it.trap || cfg_rdata !== it.sts) begin
            errors++;
            $display("FAIL %s: trap=%b status=%h expected trap=%b status=%h",
                     it.tag, trap_o, cfg_rdata, it.trap, it.sts);
         end
      end
   end

   task automatic wr(input logic [2:0] s, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0; cfg_sel = 3'd5; cfg_wdata = '0;
   endtask

   task automatic rd_chk(input logic [2:0] s, input logic [31:0] exp, input string tag);
      @(negedge clk);
      cfg_sel = s;
      #1;
      checks++;
      if (cfg_rdata !== exp) begin
         errors++;
         $display("FAIL %s: sel=%0d read=%h expected=%h", tag, s, cfg_rdata, exp);
      end
      cfg_sel = 3'd5;
   endtask

   task automatic stim(input logic v, input logic [31:0] a, input logic [1:0] sz,
                       input logic [1:0] kd, input logic st, input logic sw,
                       input logic wst, input logic [31:0] wd,
                       input logic etrap, input logic [31:0] ests, input string tag);
      @(negedge clk);
      acc_valid = v; acc_addr = a; acc_size = sz; acc_kind = kd;
      step_evt = st; tswitch_evt = sw;
      cfg_sel = 3'd5; cfg_we = wst; cfg_wdata = wd;
      @(posedge clk);
      sb.push_back('{etrap, ests, tag});
      @(negedge clk);
      acc_valid = 1'b0; acc_kind = 2'b11; step_evt = 1'b0; tswitch_evt = 1'b0;
      cfg_we = 1'b0; cfg_wdata = '0;
      @(posedge clk);
      sb.push_back('{1'b0, ests, {tag, " R10 pulse end"}});
   endtask

   task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic [1:0] kd,
                         input logic etrap, input logic [31:0] ests, input string tag);
      stim(1'b1, a, sz, kd, 1'b0, 1'b0, 1'b0, '0, etrap, ests, tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < 6; i++) rd_chk(3'(i), 32'h0, "R1 reset value");
      checks++;
      if (trap_o !== 1'b0) begin
         errors++;
         $display("FAIL R1: trap=%b expected=0", trap_o);
      end

      // R2 reserved bits
      wr(3'd4, 32'hFFFF_FFFF);
      rd_chk(3'd4, 32'hFFFF_03FF, "R2 reserved masked");
      wr(3'd4, 32'h0);

      // R5 execute slot 0, global enable (R3)
      wr(3'd0, 32'h0000_1000);
      rd_chk(3'd0, 32'h0000_1000, "R2 slot readback");
      wr(3'd4, 32'h0000_0002);
      access(32'h1000, 2'd0, 2'b00, 1'b1, 32'h1, "R5 R3 fetch exact");
      wr(3'd5, 32'h0);
      access(32'h1001, 2'd0, 2'b00, 1'b0, 32'h0, "R5 fetch off by one");
      access(32'h1000, 2'd0, 2'b01, 1'b0, 32'h0, "R5 read on exec slot");

      // R6 R7 slot 1 write-only, 4 bytes, local enable (R3)
      wr(3'd1, 32'h0000_2004);
      wr(3'd4, 32'h00D0_0004);
      access(32'h2006, 2'd0, 2'b10, 1'b1, 32'h2, "R6 R7 R3 write in window");
      wr(3'd5, 32'h0);
      access(32'h2006, 2'd0, 2'b01, 1'b0, 32'h0, "R6 read on write-only");
      access(32'h2003, 2'd0, 2'b10, 1'b0, 32'h0, "R7 below window");
      access(32'h2002, 2'd1, 2'b10, 1'b0, 32'h0, "R7 2-byte below window");
      access(32'h2002, 2'd2, 2'b10, 1'b1, 32'h2, "R7 overlap from below");
      wr(3'd5, 32'h0);

      // R6 R7 R8 slot 2 read/write, 8 bytes
      wr(3'd2, 32'h0000_3000);
      wr(3'd4, 32'h0BD0_0024);
      access(32'h3007, 2'd0, 2'b01, 1'b1, 32'h4, "R6 R7 read 8-byte window");
      access(32'h3000, 2'd0, 2'b10, 1'b1, 32'h4, "R8 sticky repeat");
      access(32'h2004, 2'd0, 2'b10, 1'b1, 32'h6, "R8 accumulate slot1");
      access(32'h3008, 2'd0, 2'b01, 1'b0, 32'h6, "R8 miss keeps status");

      // R6 type 10 never
      wr(3'd3, 32'h0000_4000);
      wr(3'd4, 32'h2000_0080);
      wr(3'd5, 32'h0);
      access(32'h4000, 2'd0, 2'b10, 1'b0, 32'h0, "R6 never write");
      access(32'h4000, 2'd0, 2'b01, 1'b0, 32'h0, "R6 never read");
      access(32'h4000, 2'd0, 2'b00, 1'b0, 32'h0, "R6 never fetch");

      // R9 single step
      stim(1'b0, '0, 2'd0, 2'b11, 1'b1, 1'b0, 1'b0, '0, 1'b1, 32'h4000, "R9 step");
      wr(3'd5, 32'h0);

      // R4 task switch
      wr(3'd4, 32'h0000_00FF);
      stim(1'b0, '0, 2'd0, 2'b11, 1'b0, 1'b1, 1'b0, '0, 1'b1, 32'h8000, "R4 switch");
      rd_chk(3'd4, 32'h0000_00AA, "R4 locals cleared");
      wr(3'd5, 32'h0);

      // R11 write and hit in the same cycle, then write mask
      wr(3'd4, 32'h0000_0002);
      stim(1'b1, 32'h1000, 2'd0, 2'b00, 1'b0, 1'b0, 1'b1, 32'h0000_4000,
           1'b1, 32'h4001, "R11 write with hit");
      wr(3'd5, 32'hFFFF_FFFF);
      rd_chk(3'd5, 32'h0000_C00F, "R11 status write mask");
      wr(3'd5, 32'h0);

      // R12 all zero disables
      wr(3'd4, 32'h0);
      for (int i = 0; i < 4; i++) wr(3'(i), 32'h0);
      access(32'h0, 2'd0, 2'b00, 1'b0, 32'h0, "R12 fetch at zero");
      access(32'h0, 2'd3, 2'b10, 1'b0, 32'h0, "R12 write at zero");

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule